// File: doc/BRIEF.md
# Serial Register Burst-Read Sequencer

This block is the register slave behind the serial port of a motion sensor. A host selects the port with an active-low chip select and clocks bytes over a serial data line. The first byte of each access carries a read/write flag and a register address. A write is followed by one data byte. A read is answered with one data byte. The data line is split into an input, an output and an output enable, so that a pad cell can build the bidirectional pin.

Besides single accesses, the block has a burst read. Reading a trigger address starts a stream of motion registers. The stream begins at a programmable start register and runs through a programmable stop register, with no further address bytes and no gap between bytes. When a 12-bit motion option is on, the register that holds the upper motion bits is spliced into the stream right after the Y delta. The port accepts a new address byte only after the final byte of the stream has left. The same port also carries two control actions. One write key sends the block into power-down. A second key, written to a reset address, performs a full soft reset of the configuration.

The serial clock is sampled in the system clock domain. It must be slow enough that every level is seen for at least two system clocks.

Top module: `srb_sequencer`

## Requirements
- R1: The first byte of an access is sent MSB first, and input bits are sampled on rising edges of the serial clock. Bit 7 of this byte set to 1 means write and 0 means read. Bits 6:0 hold the register address. A write's data byte follows it directly.
- R2: A single read returns the following values. Address 0x00 gives the product-ID parameter and 0x01 gives the revision parameter. Addresses 0x02–0x09 and 0x0C give the matching motion inputs. Address 0x0E gives the 12-bit option in bit 0. Addresses 0x42 and 0x44 give the start and stop registers. Any other address reads 0x00.
- R3: The first read data bit is on the output before the first rising edge after the address byte. Read data leaves MSB first, one bit per rising edge. The output enable is high for the whole read data phase.
- R4: A read of address 0x63 starts a burst. The burst streams registers from the start register onward in the order 0x00, 0x01, …, 0x09, with no extra bytes in between.
- R5: When bit 0 of register 0x0E is 1, the burst sends 0x0C directly after 0x04 and then goes on with 0x05.
- R6: The start register 0x42 resets to 0x03. It takes a written value only if that value is 0x00–0x02 or 0x05–0x08. Any other written value is ignored.
- R7: The stop register 0x44 resets to 0x09. It takes a written value only if that value is 0x01–0x02, 0x04–0x09, or 0x0C with the 12-bit option on. The value must also be greater than the current start register. Any other written value is ignored.
- R8: A burst ends after the byte for the stop register, or after the byte for 0x09 if that comes first. The next byte, sent with chip select still low, is then decoded as a new address byte.
- R9: Chip select going high ends any access, including a burst part-way through. The next access starts with an address byte.
- R10: Writing 0x5A to address 0x3A returns the start register, the stop register, the 12-bit option and power-down to their reset values.
- R11: Writing 0x02 to address 0x0D raises the power-down output. While power-down is on, every read returns 0x00 and every write other than the soft-reset key is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle high |
| csN | input | 1 | Active-low chip select |
| sdioIn | input | 1 | Serial data from the host |
| sdioOut | output | 1 | Serial data to the host |
| sdioOe | output | 1 | Output enable for the data pin |
| motionStat | input | 8 | Value of register 0x02 |
| deltaX | input | 8 | Value of register 0x03 |
| deltaY | input | 8 | Value of register 0x04 |
| surfQual | input | 8 | Value of register 0x05 |
| shutHi | input | 8 | Value of register 0x06 |
| shutLo | input | 8 | Value of register 0x07 |
| pixMax | input | 8 | Value of register 0x08 |
| pixSum | input | 8 | Value of register 0x09 |
| deltaHigh | input | 8 | Value of register 0x0C |
| powerDown | output | 1 | High while power-down is on |

## Verification
The hardest states to reach from the ports are the unusual burst windows. These include a start register above the stop register, a stop value of 0x0C left in place after the 12-bit option is cleared, and a stop value at 0x0C while the start lies past 0x04. Each of these needs a certain order of configuration writes, some of which are only legal at certain times. The stimulus sends many seeded random writes to the start, stop and option registers, some legal and some not, and runs a burst after each one. A bench model tracks which writes took effect and predicts every byte of each stream. Directed cases add a burst cut short by chip select, a back-to-back address right after a burst, and a power-down followed by the reset key.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int BIT_CNT_W = $clog2(DATA_W);
  localparam logic [BIT_CNT_W-1:0] BIT_LAST = BIT_CNT_W'(DATA_W - 1);

  localparam logic [ADDR_W-1:0] A_PROD  = 7'h00;
  localparam logic [ADDR_W-1:0] A_REV   = 7'h01;
  localparam logic [ADDR_W-1:0] A_MSTAT = 7'h02;
  localparam logic [ADDR_W-1:0] A_DX    = 7'h03;
  localparam logic [ADDR_W-1:0] A_DY    = 7'h04;
  localparam logic [ADDR_W-1:0] A_QUAL  = 7'h05;
  localparam logic [ADDR_W-1:0] A_SHH   = 7'h06;
  localparam logic [ADDR_W-1:0] A_SHL   = 7'h07;
  localparam logic [ADDR_W-1:0] A_PMAX  = 7'h08;
  localparam logic [ADDR_W-1:0] A_PSUM  = 7'h09;
  localparam logic [ADDR_W-1:0] A_DHI   = 7'h0C;
  localparam logic [ADDR_W-1:0] A_PWR   = 7'h0D;
  localparam logic [ADDR_W-1:0] A_CFG   = 7'h0E;
  localparam logic [ADDR_W-1:0] A_SRST  = 7'h3A;
  localparam logic [ADDR_W-1:0] A_START = 7'h42;
  localparam logic [ADDR_W-1:0] A_STOP  = 7'h44;
  localparam logic [ADDR_W-1:0] A_BURST = 7'h63;

  localparam logic [ADDR_W-1:0] START_DEF = A_DX;
  localparam logic [ADDR_W-1:0] STOP_DEF  = A_PSUM;
  localparam logic [DATA_W-1:0] SRST_KEY  = 8'h5A;
  localparam logic [DATA_W-1:0] PWR_KEY   = 8'h02;

  typedef enum logic [1:0] {PH_ADDR, PH_WRDATA, PH_RDDATA} phase_e;

  typedef struct packed {
    logic              shiftEn;
    logic              loadEn;
    logic [ADDR_W-1:0] loadAddr;
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
  } ctrlStrb_t;

  // burst walk: the upper motion bits are spliced in after the Y delta
  function automatic logic [ADDR_W-1:0] burstNext(input logic [ADDR_W-1:0] cur,
                                                  input logic mode12);
    if (cur == A_DY && mode12) return A_DHI;
    if (cur == A_DHI)          return A_QUAL;
    return cur + 7'd1;
  endfunction

  function automatic logic burstStop(input logic [ADDR_W-1:0] cur,
                                     input logic [ADDR_W-1:0] stopAddr);
    return (cur == stopAddr) || (cur == A_PSUM);
  endfunction

  function automatic logic startOk(input logic [DATA_W-1:0] v);
    return (v <= 8'h02) || (v >= 8'h05 && v <= 8'h08);
  endfunction

  function automatic logic stopOk(input logic [DATA_W-1:0] v,
                                  input logic [ADDR_W-1:0] startAddr,
                                  input logic mode12);
    logic inSet;
    inSet = (v >= 8'h01 && v <= 8'h02) || (v >= 8'h04 && v <= 8'h09) ||
            (v == 8'h0C && mode12);
    return inSet && (v > {1'b0, startAddr});
  endfunction
endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] stopAddr,
  input  logic              mode12,
  output ctrlStrb_t         strb,
  output logic              sdioOe
);
  logic                 sclkQ;
  logic                 sclkRise;
  logic                 byteDone;
  phase_e               phase;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic                 burstOn;
  logic [ADDR_W-1:0]    cursor;
  logic [ADDR_W-1:0]    wrAddrQ;
  logic [ADDR_W-1:0]    rxAddr;
  logic                 rxIsWrite;

  assign sclkRise  = sclk & ~sclkQ & ~csN;
  assign byteDone  = sclkRise && (bitCnt == BIT_LAST);
  assign rxAddr    = rxByte[ADDR_W-1:0];
  assign rxIsWrite = rxByte[DATA_W-1];
  assign sdioOe    = (phase == PH_RDDATA) && !csN;

  always_comb begin
    strb = '0;
    strb.wrAddr = wrAddrQ;
    strb.shiftEn = sclkRise;
    if (byteDone) begin
      unique case (phase)
        PH_ADDR: begin
          if (!rxIsWrite) begin
            strb.loadEn   = 1'b1;
            strb.loadAddr = (rxAddr == A_BURST) ? startAddr : rxAddr;
          end
        end
        PH_WRDATA: strb.wrEn = 1'b1;
        PH_RDDATA: begin
          if (burstOn && !burstStop(cursor, stopAddr)) begin
            strb.loadEn   = 1'b1;
            strb.loadAddr = burstNext(cursor, mode12);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b1;
      phase   <= PH_ADDR;
      bitCnt  <= '0;
      burstOn <= 1'b0;
      cursor  <= '0;
      wrAddrQ <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        phase   <= PH_ADDR;
        bitCnt  <= '0;
        burstOn <= 1'b0;
      end else if (sclkRise) begin
        bitCnt <= bitCnt + 1'b1;
        if (byteDone) begin
          unique case (phase)
            PH_ADDR: begin
              if (rxIsWrite) begin
                wrAddrQ <= rxAddr;
                phase   <= PH_WRDATA;
              end else begin
                phase   <= PH_RDDATA;
                burstOn <= (rxAddr == A_BURST);
                cursor  <= (rxAddr == A_BURST) ? startAddr : rxAddr;
              end
            end
            PH_WRDATA: phase <= PH_ADDR;
            PH_RDDATA: begin
              if (burstOn && !burstStop(cursor, stopAddr)) begin
                cursor <= burstNext(cursor, mode12);
              end else begin
                phase   <= PH_ADDR;
                burstOn <= 1'b0;
              end
            end
            default: phase <= PH_ADDR;
          endcase
        end
      end
    end
  end

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (phase == PH_ADDR && !burstOn && bitCnt == '0)); // R9
  AST_OE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> (csN || sdioOe)); // R3
  AST_BURST_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    burstOn |-> (phase == PH_RDDATA)); // R8
  AST_CURSOR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    burstOn |-> (cursor <= A_PSUM || cursor == A_DHI)); // R4
endmodule

// File: rtl/srb_datapath.sv
module srb_datapath
  import srb_pkg::*;
#(
  parameter logic [DATA_W-1:0] PRODUCT_ID  = 8'h31,
  parameter logic [DATA_W-1:0] REVISION_ID = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              sdioIn,
  input  logic [DATA_W-1:0] motionStat,
  input  logic [DATA_W-1:0] deltaX,
  input  logic [DATA_W-1:0] deltaY,
  input  logic [DATA_W-1:0] surfQual,
  input  logic [DATA_W-1:0] shutHi,
  input  logic [DATA_W-1:0] shutLo,
  input  logic [DATA_W-1:0] pixMax,
  input  logic [DATA_W-1:0] pixSum,
  input  logic [DATA_W-1:0] deltaHigh,
  output logic [DATA_W-1:0] rxByte,
  output logic              sdioOut,
  output logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] stopAddr,
  output logic              mode12,
  output logic              powerDown
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] rdVal;
  logic              softRst;

  assign rxByte  = {shReg[DATA_W-2:0], sdioIn};
  assign sdioOut = shReg[DATA_W-1];
  assign softRst = strb.wrEn && (strb.wrAddr == A_SRST) && (rxByte == SRST_KEY);

  always_comb begin
    rdVal = '0;
    if (!powerDown) begin
      unique case (strb.loadAddr)
        A_PROD:  rdVal = PRODUCT_ID;
        A_REV:   rdVal = REVISION_ID;
        A_MSTAT: rdVal = motionStat;
        A_DX:    rdVal = deltaX;
        A_DY:    rdVal = deltaY;
        A_QUAL:  rdVal = surfQual;
        A_SHH:   rdVal = shutHi;
        A_SHL:   rdVal = shutLo;
        A_PMAX:  rdVal = pixMax;
        A_PSUM:  rdVal = pixSum;
        A_DHI:   rdVal = deltaHigh;
        A_CFG:   rdVal = {{(DATA_W-1){1'b0}}, mode12};
        A_START: rdVal = {1'b0, startAddr};
        A_STOP:  rdVal = {1'b0, stopAddr};
        default: rdVal = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.loadEn) begin
      shReg <= rdVal;
    end else if (strb.shiftEn) begin
      shReg <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr <= START_DEF;
      stopAddr  <= STOP_DEF;
      mode12    <= 1'b0;
      powerDown <= 1'b0;
    end else if (softRst) begin
      startAddr <= START_DEF;
      stopAddr  <= STOP_DEF;
      mode12    <= 1'b0;
      powerDown <= 1'b0;
    end else if (strb.wrEn && !powerDown) begin
      unique case (strb.wrAddr)
        A_START: if (startOk(rxByte)) startAddr <= rxByte[ADDR_W-1:0];
        A_STOP:  if (stopOk(rxByte, startAddr, mode12)) stopAddr <= rxByte[ADDR_W-1:0];
        A_CFG:   mode12 <= rxByte[0];
        A_PWR:   if (rxByte == PWR_KEY) powerDown <= 1'b1;
        default: ;
      endcase
    end
  end

  AST_START_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrAddr == A_START && !startOk(rxByte)) |=> $stable(startAddr)); // R6
  AST_STOP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrAddr == A_STOP && !stopOk(rxByte, startAddr, mode12))
      |=> $stable(stopAddr)); // R7
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (startAddr == START_DEF && stopAddr == STOP_DEF && !mode12 && !powerDown)); // R10
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && !softRst) |=> powerDown); // R11
  AST_PD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && strb.loadEn) |=> (shReg == '0)); // R11
endmodule

// File: rtl/srb_sequencer.sv
module srb_sequencer
  import srb_pkg::*;
#(
  parameter logic [7:0] PRODUCT_ID  = 8'h31,
  parameter logic [7:0] REVISION_ID = 8'h03
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       sdioIn,
  output logic       sdioOut,
  output logic       sdioOe,
  input  logic [7:0] motionStat,
  input  logic [7:0] deltaX,
  input  logic [7:0] deltaY,
  input  logic [7:0] surfQual,
  input  logic [7:0] shutHi,
  input  logic [7:0] shutLo,
  input  logic [7:0] pixMax,
  input  logic [7:0] pixSum,
  input  logic [7:0] deltaHigh,
  output logic       powerDown
);
  ctrlStrb_t         strb;
  logic [DATA_W-1:0] rxByte;
  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] stopAddr;
  logic              mode12;

  srb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .rxByte(rxByte),
    .startAddr(startAddr), .stopAddr(stopAddr), .mode12(mode12),
    .strb(strb), .sdioOe(sdioOe)
  );

  srb_datapath #(.PRODUCT_ID(PRODUCT_ID), .REVISION_ID(REVISION_ID)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdioIn(sdioIn),
    .motionStat(motionStat), .deltaX(deltaX), .deltaY(deltaY),
    .surfQual(surfQual), .shutHi(shutHi), .shutLo(shutLo),
    .pixMax(pixMax), .pixSum(pixSum), .deltaHigh(deltaHigh),
    .rxByte(rxByte), .sdioOut(sdioOut), .startAddr(startAddr),
    .stopAddr(stopAddr), .mode12(mode12), .powerDown(powerDown)
  );
endmodule

// File: tb/srb_sequencer_tb_top.sv
module srb_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PID = 8'h31;
  localparam logic [7:0] RID = 8'h03;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b1;
  logic csN = 1'b1;
  logic sdioIn = 1'b0;
  logic sdioOut, sdioOe, powerDown;
  logic [7:0] motVal [2:9];
  logic [7:0] hiVal;

  int total = 0;
  int bad = 0;
  logic [7:0] expStart, expStop;
  logic expMode, expPd;

  always #(CLK_PERIOD/2) clk = ~clk;

  srb_sequencer #(.PRODUCT_ID(PID), .REVISION_ID(RID)) dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .motionStat(motVal[2]),
    .deltaX(motVal[3]), .deltaY(motVal[4]), .surfQual(motVal[5]),
    .shutHi(motVal[6]), .shutLo(motVal[7]), .pixMax(motVal[8]),
    .pixSum(motVal[9]), .deltaHigh(hiVal), .powerDown(powerDown)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    if (expPd) return 8'h00;
    if (a == 8'h00) return PID;
    if (a == 8'h01) return RID;
    if (a >= 8'h02 && a <= 8'h09) return motVal[a[3:0]];
    if (a == 8'h0C) return hiVal;
    if (a == 8'h0E) return {7'd0, expMode};
    if (a == 8'h42) return expStart;
    if (a == 8'h44) return expStop;
    return 8'h00;
  endfunction

  function automatic logic [7:0] modelNext(input logic [7:0] c);
    if (c == 8'h04 && expMode) return 8'h0C;
    if (c == 8'h0C) return 8'h05;
    return c + 8'd1;
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h3A && d == 8'h5A) begin
      expStart = 8'h03; expStop = 8'h09; expMode = 1'b0; expPd = 1'b0;
    end else if (!expPd) begin
      if (a == 8'h42 && ((d <= 8'h02) || (d >= 8'h05 && d <= 8'h08))) expStart = d;
      if (a == 8'h44 && ((d >= 8'h01 && d <= 8'h02) || (d >= 8'h04 && d <= 8'h09) ||
                         (d == 8'h0C && expMode)) && d > expStart) expStop = d;
      if (a == 8'h0E) expMode = d[0];
      if (a == 8'h0D && d == 8'h02) expPd = 1'b1;
    end
  endtask

  task automatic xfer(input logic [7:0] txv, output logic [7:0] rxv, output logic oeAll);
    oeAll = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sclk = 1'b0;
      sdioIn = txv[i];
      repeat (3) @(negedge clk);
      rxv[i] = sdioOut;
      oeAll &= sdioOe;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic txnStart();
    @(negedge clk); csN = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic txnEnd();
    repeat (2) @(negedge clk); csN = 1'b1; repeat (3) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r; logic o;
    txnStart();
    xfer({1'b1, a[6:0]}, r, o);
    xfer(d, r, o);
    txnEnd();
    modelWrite(a, d);
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d, output logic oe);
    logic [7:0] r; logic o;
    txnStart();
    xfer({1'b0, a[6:0]}, r, o);
    xfer(8'h00, d, oe);
    txnEnd();
  endtask

  // burst, then a back-to-back single read of the stop register in the same select
  task automatic doBurst(input string tag);
    logic [7:0] r, got, cur; logic o, oe;
    txnStart();
    xfer(8'h63, r, o);
    cur = expStart;
    for (int n = 0; n < 16; n++) begin
      xfer(8'h00, got, oe);
      chk({tag, " R4 burst byte"}, got, modelRead(cur));
      chk({tag, " R3 oe in burst"}, {7'd0, oe}, 8'h01);
      if (cur == expStop || cur == 8'h09) break;
      cur = modelNext(cur);
    end
    xfer({1'b0, 7'h44}, r, o);
    xfer(8'h00, got, oe);
    chk({tag, " R8 address after burst"}, got, modelRead(8'h44));
    txnEnd();
  endtask

  task automatic newMotion();
    for (int i = 2; i <= 9; i++) motVal[i] = 8'($urandom);
    hiVal = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, r; logic oe, o;
    void'($urandom(32'h5EED));
    expStart = 8'h03; expStop = 8'h09; expMode = 1'b0; expPd = 1'b0;
    newMotion();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    chk("R11 powerDown at reset", {7'd0, powerDown}, 8'h00);
    chk("R3 oe idle", {7'd0, sdioOe}, 8'h00);
    regRead(8'h42, d, oe); chk("R6 start reset value", d, 8'h03);
    regRead(8'h44, d, oe); chk("R7 stop reset value", d, 8'h09);
    regRead(8'h00, d, oe); chk("R2 product id", d, PID);
    chk("R3 oe in single read", {7'd0, oe}, 8'h01);
    regRead(8'h01, d, oe); chk("R2 revision", d, RID);
    regRead(8'h07, d, oe); chk("R2 shutter low", d, motVal[7]);
    regRead(8'h20, d, oe); chk("R2 unmapped", d, 8'h00);

    doBurst("default");

    regWrite(8'h0E, 8'h01);
    regRead(8'h0E, d, oe); chk("R1 write then read option", d, 8'h01);
    regWrite(8'h44, 8'h0C);
    regRead(8'h44, d, oe); chk("R7 stop 0x0C with option", d, 8'h0C);
    newMotion();
    doBurst("R5 twelve-bit");

    regWrite(8'h42, 8'h03); regRead(8'h42, d, oe); chk("R6 illegal start ignored", d, 8'h03);
    regWrite(8'h42, 8'h01); regRead(8'h42, d, oe); chk("R6 legal start", d, 8'h01);
    regWrite(8'h44, 8'h03); regRead(8'h44, d, oe); chk("R7 illegal stop ignored", d, 8'h0C);
    regWrite(8'h42, 8'h06);
    regWrite(8'h44, 8'h05); regRead(8'h44, d, oe); chk("R7 stop not above start", d, 8'h0C);
    doBurst("R8 end at 0x09");

    // chip select removed part-way through a burst
    txnStart();
    xfer(8'h63, r, o);
    xfer(8'h00, r, o);
    xfer(8'h00, r, o);
    txnEnd();
    regRead(8'h42, d, oe); chk("R9 access after abort", d, expStart);

    for (int it = 0; it < 30; it++) begin
      int sel;
      logic [7:0] v;
      sel = $urandom_range(0, 2);
      v = 8'($urandom_range(0, 15));
      case (sel)
        0: regWrite(8'h42, v);
        1: regWrite(8'h44, v);
        default: regWrite(8'h0E, {7'd0, v[0]});
      endcase
      newMotion();
      doBurst("random");
    end

    regWrite(8'h42, 8'h02);
    regWrite(8'h0D, 8'h02);
    chk("R11 powerDown raised", {7'd0, powerDown}, 8'h01);
    regRead(8'h05, d, oe); chk("R11 read in power-down", d, 8'h00);
    regWrite(8'h0D, 8'h00);
    chk("R11 stays down", {7'd0, powerDown}, 8'h01);
    regWrite(8'h3A, 8'h5A);
    chk("R10 powerDown cleared", {7'd0, powerDown}, 8'h00);
    regRead(8'h42, d, oe); chk("R10 start default", d, 8'h03);
    regRead(8'h44, d, oe); chk("R10 stop default", d, 8'h09);
    regRead(8'h0E, d, oe); chk("R10 option default", d, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule